// File: doc/BRIEF.md
# Microstep-to-Fullstep Flow-Control Gate

This block sits between a STEP/DIR pulse interface and a fullstep executor. Step pulses arrive at microstep resolution. The block groups them into fullsteps: after 2^k microsteps it emits one fullstep pulse, with the direction of the microstep that completed the group. When gating is enabled, each fullstep must be confirmed by the motor before the next one may run. The block holds its ready output low until the motor-done strobe arrives, and the motion controller is expected to pause while ready is low.

While the block waits, incoming microsteps go into an ordered buffer that holds at most one fullstep's worth minus one. A microstep that finds the buffer full is discarded and recorded in a signed, saturating lost-step tally: it counts up for DIR high and down for DIR low. A STEP pulse held high long enough breaks a stalled wait without motor confirmation. With gating disabled, microsteps go straight to the grouping counter and ready stays high.

Top module: `stepgate`

## Requirements
- R1: STEP and DIR each pass through two synchronising flops, and a step is taken on each synchronised rising edge of STEP. With gate_en low, every N accepted steps (N = 2^k) produce one fs_pulse_o, fs_dir_o equals the DIR of the completing step, and ready_o stays 1.
- R2: With gate_en high, the clock that raises fs_pulse_o also drops ready_o to 0. No further fullstep is issued while ready_o is 0, and ready_o returns to 1 in the cycle after motor_done is sampled high.
- R3: A step that arrives while ready_o is 0, or while buffered steps remain, is stored in arrival order. The buffer holds at most N-1 steps.
- R4: A step that finds N-1 steps already stored is discarded. lost_cnt_o (two's complement) then changes by +1 if DIR is 1 and by -1 if DIR is 0.
- R5: Once ready_o is 1, stored steps move into the grouping counter at one per clock. They count toward the next fullstep exactly like new steps.
- R6: If the synchronised STEP stays high for OVR_CLKS clocks while ready_o is 0, the wait ends without motor confirmation: ready_o goes to 1 and buffering stops. This happens once per pulse, and the pulse's own rising edge still counts as a step.
- R7: lost_cnt_o saturates at its largest positive and most negative values instead of wrapping.
- R8: lost_clr set to 1 clears lost_cnt_o to 0 at the next clock and takes priority over a simultaneous loss.
- R9: res_log2 = k selects N = 2^k. Codes above MAX_LOG2 select N = 2^MAX_LOG2. With k = 0 the buffer depth is zero, so every step that arrives while ready_o is 0 is lost.
- R10: motor_done has no effect while ready_o is 1. The grouping count and lost_cnt_o are unchanged.
- R11: After reset, ready_o = 1, fs_pulse_o = 0 and lost_cnt_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Microstep pulse, asynchronous |
| dir_in | input | 1 | Direction, 1 = positive |
| gate_en | input | 1 | Enables confirmation gating and buffering |
| motor_done | input | 1 | Strobe: motor has taken the last fullstep |
| res_log2 | input | $clog2(MAX_LOG2+1) | Microsteps per fullstep, as a power of two |
| lost_clr | input | 1 | Synchronous clear of the lost-step tally |
| ready_o | output | 1 | 1 = controller may send steps |
| fs_pulse_o | output | 1 | One-clock fullstep command |
| fs_dir_o | output | 1 | Direction of the current fullstep |
| lost_cnt_o | output | LOST_W | Signed lost-step tally |

## Verification
The bench builds the block with MAX_LOG2 = 4, OVR_CLKS = 64 and LOST_W = 6. With these values, filling the 15-deep buffer, triggering the long-pulse override and hitting both saturation limits (+31 and -32) all take only a few hundred clocks. The 3-bit resolution code can also carry the value 7, which tests the clamp to 16 microsteps. A reference model predicts each fullstep direction in order, and these are compared as fs_pulse_o fires. Ready and the lost tally are checked at quiet points between stimulus steps.

// File: rtl/stepgate_pkg.sv
package stepgate_pkg;

  // Destination of a synchronised microstep in the current cycle
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_ACC  = 2'd1,
    ROUTE_BUF  = 2'd2,
    ROUTE_LOST = 2'd3
  } route_e;

endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/sg_step_front.sv
module sg_step_front #(
  parameter int OVR_CLKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  input  logic dir_in,
  output logic step_rise,
  output logic step_dir,
  output logic ovr_fire
);

  localparam int CNT_W = $clog2(OVR_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(OVR_CLKS);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(OVR_CLKS - 1);

  logic s_meta_q, s_sync_q, s_prev_q;
  logic d_meta_q, d_sync_q;
  logic [CNT_W-1:0] hold_q, hold_d;

  // Hold counter: high cycles seen so far, saturating at CNT_TOP
  always_comb begin
    if (!s_sync_q)             hold_d = '0;
    else if (hold_q == CNT_TOP) hold_d = hold_q;
    else                        hold_d = hold_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta_q <= 1'b0;
      s_sync_q <= 1'b0;
      s_prev_q <= 1'b0;
      d_meta_q <= 1'b0;
      d_sync_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      s_meta_q <= step_in;
      s_sync_q <= s_meta_q;
      s_prev_q <= s_sync_q;
      d_meta_q <= dir_in;
      d_sync_q <= d_meta_q;
      hold_q   <= hold_d;
    end
  end

  assign step_rise = s_sync_q & ~s_prev_q;
  assign step_dir  = d_sync_q;
  // Fires in the OVR_CLKS-th high cycle; the counter then passes it once
  assign ovr_fire  = s_sync_q && (hold_q == CNT_FIRE);

endmodule

// File: rtl/sg_dir_buffer.sv
module sg_dir_buffer #(
  parameter int DEPTH = 255,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_dir,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          head_dir
);

  logic [DEPTH-1:0] mem_q, mem_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  // Pop shifts toward index 0; push writes at the fill level
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic above;
    if (i == DEPTH - 1) begin : g_top
      assign above = 1'b0;
    end else begin : g_mid
      assign above = mem_q[i+1];
    end
    assign mem_d[i] = pop ? above
                    : ((push && (cnt_q == CW'(i))) ? push_dir : mem_q[i]);
  end

  always_comb begin
    if (pop)       cnt_d = cnt_q - 1'b1;
    else if (push) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  assign count    = cnt_q;
  assign head_dir = mem_q[0];

endmodule

// File: rtl/sg_lost_counter.sv
module sg_lost_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = '0;
    else if (inc && cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
    else if (dec && cnt_q != MINV) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr || inc || dec) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/stepgate.sv
module stepgate #(
  parameter int MAX_LOG2 = 8,
  parameter int OVR_CLKS = 1024,
  parameter int LOST_W   = 20,
  localparam int RES_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_in,
  input  logic              dir_in,
  input  logic              gate_en,
  input  logic              motor_done,
  input  logic [RES_W-1:0]  res_log2,
  input  logic              lost_clr,
  output logic              ready_o,
  output logic              fs_pulse_o,
  output logic              fs_dir_o,
  output logic [LOST_W-1:0] lost_cnt_o
);

  import stepgate_pkg::*;

  localparam int MAXU      = 1 << MAX_LOG2;
  localparam int BUF_DEPTH = MAXU - 1;
  localparam int ACC_W     = $clog2(BUF_DEPTH + 1);

  logic rst_sync_n;
  logic step_rise, step_dir, ovr_fire;

  logic [RES_W-1:0] res_eff;
  logic [ACC_W-1:0] lim_m1;
  logic [ACC_W-1:0] buf_cnt;
  logic             head_dir;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             wait_q, wait_d;
  logic             fs_q, fs_d;
  logic             fsdir_q, fsdir_d;

  route_e route;
  logic   waiting, holding, pop, acc_step, acc_dir, complete;

  sg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sg_step_front #(.OVR_CLKS(OVR_CLKS)) u_front (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_in   (step_in),
    .dir_in    (dir_in),
    .step_rise (step_rise),
    .step_dir  (step_dir),
    .ovr_fire  (ovr_fire)
  );

  // Resolution clamp and group limit (N-1)
  assign res_eff = (int'(res_log2) > MAX_LOG2) ? RES_W'(MAX_LOG2) : res_log2;
  assign lim_m1  = ACC_W'((MAXU - 1) >> (MAX_LOG2 - int'(res_eff)));

  assign waiting = wait_q && gate_en;
  assign holding = waiting || (buf_cnt != '0);

  always_comb begin
    route = ROUTE_NONE;
    if (step_rise) begin
      if (!holding)              route = ROUTE_ACC;
      else if (buf_cnt < lim_m1) route = ROUTE_BUF;
      else                       route = ROUTE_LOST;
    end
  end

  assign pop      = !step_rise && !waiting && (buf_cnt != '0);
  assign acc_step = (route == ROUTE_ACC) || pop;
  assign acc_dir  = pop ? head_dir : step_dir;
  assign complete = acc_step && (acc_q >= lim_m1);

  sg_dir_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (route == ROUTE_BUF),
    .push_dir (step_dir),
    .pop      (pop),
    .count    (buf_cnt),
    .head_dir (head_dir)
  );

  sg_lost_counter #(.W(LOST_W)) u_lost (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (lost_clr),
    .inc   ((route == ROUTE_LOST) &&  step_dir),
    .dec   ((route == ROUTE_LOST) && !step_dir),
    .cnt   (lost_cnt_o)
  );

  // Next-state logic
  always_comb begin
    acc_d   = acc_q;
    wait_d  = wait_q;
    fs_d    = complete;
    fsdir_d = fsdir_q;
    if (acc_step) acc_d = complete ? '0 : acc_q + 1'b1;
    if (complete) fsdir_d = acc_dir;
    if (!gate_en)                    wait_d = 1'b0;
    else if (complete)               wait_d = 1'b1;
    else if (motor_done || ovr_fire) wait_d = 1'b0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      wait_q  <= 1'b0;
      fs_q    <= 1'b0;
      fsdir_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      wait_q  <= wait_d;
      fs_q    <= fs_d;
      fsdir_q <= fsdir_d;
    end
  end

  assign ready_o    = !waiting;
  assign fs_pulse_o = fs_q;
  assign fs_dir_o   = fsdir_q;

endmodule

// File: rtl/stepgate_chk.sv
module stepgate_chk #(
  parameter int ACC_W  = 8,
  parameter int LOST_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic              motor_done,
  input logic              lost_clr,
  input logic              ready_o,
  input logic              fs_pulse_o,
  input logic [LOST_W-1:0] lost_cnt,
  input logic [ACC_W-1:0]  buf_cnt,
  input logic [ACC_W-1:0]  lim_m1,
  input logic              ovr_fire
);

  localparam logic [LOST_W-1:0] LMAX = {1'b0, {(LOST_W-1){1'b1}}};
  localparam logic [LOST_W-1:0] LMIN = {1'b1, {(LOST_W-1){1'b0}}};

  assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && motor_done) |=> ready_o);

  assert_hold_while_waiting_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !motor_done && !ovr_fire) |=> !fs_pulse_o);

  assert_fullstep_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_pulse_o && gate_en && $past(gate_en)) |-> !ready_o);

  assert_buffer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lim_m1) && ($past(buf_cnt) <= lim_m1)) |-> (buf_cnt <= lim_m1));

  assert_drain_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_cnt < $past(buf_cnt)) |-> (buf_cnt == $past(buf_cnt) - 1'b1));

  assert_lost_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lost_cnt) == LMAX) && !$past(lost_clr)) |-> (lost_cnt != LMIN));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_clr |=> (lost_cnt == '0));

endmodule

bind stepgate stepgate_chk #(.ACC_W(ACC_W), .LOST_W(LOST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .gate_en    (gate_en),
  .motor_done (motor_done),
  .lost_clr   (lost_clr),
  .ready_o    (ready_o),
  .fs_pulse_o (fs_pulse_o),
  .lost_cnt   (lost_cnt_o),
  .buf_cnt    (buf_cnt),
  .lim_m1     (lim_m1),
  .ovr_fire   (ovr_fire)
);

// File: tb/stepgate_tb.sv
`timescale 1ns/1ps
module stepgate_tb;

  localparam int MAX_LOG2 = 4;
  localparam int OVR      = 64;
  localparam int LW       = 6;
  localparam int LMAX     = 31;
  localparam int LMIN     = -32;

  logic clk = 1'b0;
  logic rst_n, step_in, dir_in, gate_en, motor_done, lost_clr;
  logic [2:0] res_log2;
  logic ready_o, fs_pulse_o, fs_dir_o;
  logic [LW-1:0] lost_cnt_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model
  int m_acc = 0, m_n = 4, m_lost = 0;
  bit m_wait = 0, m_en = 0;
  bit m_buf[$];
  bit exp_q[$];

  always #2.5 clk = ~clk;

  stepgate #(.MAX_LOG2(MAX_LOG2), .OVR_CLKS(OVR), .LOST_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
    .gate_en(gate_en), .motor_done(motor_done), .res_log2(res_log2),
    .lost_clr(lost_clr), .ready_o(ready_o), .fs_pulse_o(fs_pulse_o),
    .fs_dir_o(fs_dir_o), .lost_cnt_o(lost_cnt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void m_acc_step(bit d);
    m_acc++;
    if (m_acc >= m_n) begin
      m_acc = 0;
      exp_q.push_back(d);
      if (m_en) m_wait = 1;
    end
  endfunction

  function automatic void m_step(bit d);
    if ((m_wait && m_en) || m_buf.size() > 0) begin
      if (m_buf.size() < m_n - 1) m_buf.push_back(d);
      else if (d) m_lost = (m_lost == LMAX) ? LMAX : m_lost + 1;
      else        m_lost = (m_lost == LMIN) ? LMIN : m_lost - 1;
    end else begin
      m_acc_step(d);
    end
  endfunction

  function automatic void m_release();
    m_wait = 0;
    while (m_buf.size() > 0 && !(m_wait && m_en)) m_acc_step(m_buf.pop_front());
  endfunction

  task automatic do_step(input bit d, input int hi);
    m_step(d);
    if (hi >= OVR && m_en && m_wait) m_release();
    @(negedge clk); dir_in = d; step_in = 1'b1;
    repeat (hi) @(negedge clk);
    step_in = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic steps(input bit d, input int n);
    for (int i = 0; i < n; i++) do_step(d, 3);
  endtask

  task automatic confirm();
    if (m_en) m_release();
    @(negedge clk); motor_done = 1'b1;
    @(negedge clk); motor_done = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  // Scoreboard monitor: each fullstep pops one expected direction
  always @(negedge clk) begin
    if (rst_n && fs_pulse_o && !finished) begin
      if (exp_q.size() == 0) check("R1 R5 unexpected fullstep", 1, 0);
      else check("R1 R5 fullstep direction", int'(fs_dir_o), int'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; step_in = 0; dir_in = 0; gate_en = 0; motor_done = 0;
    lost_clr = 0; res_log2 = 3'd2;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    // R11 reset state
    check("R11 ready", int'(ready_o), 1);
    check("R11 fs_pulse", int'(fs_pulse_o), 0);
    check("R11 lost", int'($signed(lost_cnt_o)), 0);

    // R1 pass-through with gating off, N=4
    steps(1'b1, 4);
    check("R1 ready with gate off", int'(ready_o), 1);
    steps(1'b0, 3); do_step(1'b1, 3);
    check("R1 ready stays high", int'(ready_o), 1);
    check("R1 all fullsteps seen", exp_q.size(), 0);

    // R2 gating on
    gate_en = 1; m_en = 1;
    steps(1'b1, 4);
    check("R2 ready low after fullstep", int'(ready_o), 0);
    // R3 three buffered, no fullstep, no loss
    steps(1'b1, 3);
    check("R3 still waiting", int'(ready_o), 0);
    check("R3 no loss while buffering", int'($signed(lost_cnt_o)), 0);
    // R4 overflow counts by direction
    steps(1'b1, 2);
    check("R4 lost up", int'($signed(lost_cnt_o)), 2);
    do_step(1'b0, 3);
    check("R4 lost down", int'($signed(lost_cnt_o)), 1);
    // R2 confirmation, R5 drain of 3 into the group
    confirm();
    check("R2 ready after done", int'(ready_o), 1);
    check("R5 drained no fullstep yet", exp_q.size(), 0);
    do_step(1'b0, 3);
    check("R5 fourth step completes", int'(ready_o), 0);
    confirm();
    // R10 done while ready has no effect
    confirm();
    check("R10 ready", int'(ready_o), 1);
    check("R10 lost unchanged", int'($signed(lost_cnt_o)), m_lost);
    steps(1'b1, 3);
    check("R10 group not advanced", int'(ready_o), 1);
    do_step(1'b1, 3);
    check("R10 group completes at 4", int'(ready_o), 0);

    // R6 long pulse breaks the wait
    do_step(1'b1, OVR + 10);
    check("R6 ready after long pulse", int'(ready_o), 1);
    steps(1'b0, 3);
    check("R6 long pulse counted as step", int'(ready_o), 0);
    confirm();

    // R9 clamp: code 7 selects 16
    res_log2 = 3'd7; m_n = 16;
    steps(1'b1, 15);
    check("R9 no fullstep before 16", int'(ready_o), 1);
    do_step(1'b0, 3);
    check("R9 fullstep at 16", int'(ready_o), 0);
    confirm();

    // R9 depth zero at N=1, R7 saturation
    res_log2 = 3'd0; m_n = 1;
    do_step(1'b1, 3);
    check("R9 fullstep per step at N=1", int'(ready_o), 0);
    do_step(1'b1, 3);
    check("R9 zero depth loses step", int'($signed(lost_cnt_o)), m_lost);
    steps(1'b1, 34);
    check("R7 positive saturation", int'($signed(lost_cnt_o)), LMAX);
    steps(1'b0, 66);
    check("R7 negative saturation", int'($signed(lost_cnt_o)), LMIN);

    // R8 clear
    @(negedge clk); lost_clr = 1;
    @(negedge clk); lost_clr = 0; m_lost = 0;
    check("R8 cleared", int'($signed(lost_cnt_o)), 0);
    confirm();
    repeat (10) @(negedge clk);
    check("R1 R5 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule